// File: doc/BRIEF.md
# Password Check and Retry Lockout Unit

This unit decides whether a protected access may go ahead. It holds two 64-bit secrets. One secret guards reads. The other guards writes and secret changes. When a compare strobe arrives, the unit checks the candidate value against the secret that belongs to the requested operation. It then raises or drops a grant flag that the rest of the chip uses to open the data path.

Failed attempts are counted in one shared tally, whichever secret was tried. A success before the tally runs out clears it. A failure that arrives after the tally has reached its limit does three things: it sends a one-cycle erase request to the protected array, it zeroes both secrets, and it returns the tally to zero. While a write-side grant is held, either secret can be replaced through a change port. Bus handling and nonvolatile timing belong to the surrounding logic, and the secrets are held in flops.

Top module: `pw_guard`

## Requirements
- R1: After reset, grant_o is 0, wipe_o is 0, tries_o is 0, and both secrets equal zero, so an all-zero candidate passes for either operation.
- R2: With op_i = 0 (read) the candidate is compared with the read secret. With op_i = 1 (write) it is compared with the write secret. A value that matches only the other secret fails.
- R3: A strobe whose candidate matches sets grant_o to 1 and tries_o to 0 on the clock edge that samples the strobe.
- R4: A strobe whose candidate does not match, while tries_o is below MAX_TRIES (default 8), clears grant_o and raises tries_o by one on that edge.
- R5: Read failures and write failures add to the same tries_o count in any interleaving.
- R6: A failing strobe while tries_o equals MAX_TRIES sets wipe_o for exactly one cycle, returns tries_o to 0, clears grant_o and sets both secrets to zero.
- R7: grant_o holds its value until the next strobe or until end_i is sampled high. When end_i and a strobe arrive in the same cycle, the strobe decides the outcome.
- R8: A chg_i pulse loads chg_val_i into the read secret (chg_sel_i = 0) or the write secret (chg_sel_i = 1). The load happens only while grant_o is held from a write compare and no strobe is present in the same cycle. Otherwise chg_i is ignored.
- R9: tries_o never exceeds MAX_TRIES, and it changes only on a cycle that follows a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_i | input | 1 | Compare strobe |
| op_i | input | 1 | 0 = read access, 1 = write access |
| cand_i | input | PW_W | Candidate secret |
| end_i | input | 1 | Transaction end; drops the grant |
| chg_i | input | 1 | Secret change request |
| chg_sel_i | input | 1 | 0 = read secret, 1 = write secret |
| chg_val_i | input | PW_W | New secret value |
| grant_o | output | 1 | Access granted |
| wipe_o | output | 1 | One-cycle erase request to the array |
| tries_o | output | CNT_W | Failed-attempt count |

## Verification
A wrong tally appears on tries_o on the edge after the strobe. It also shows up as an erase pulse that fires one failure too early or too late. A corrupted or wrongly routed secret shows up only at the next compare: grant_o rises when it should stay low, or stays low when it should rise. For that reason, every change and every wipe in the bench is followed directly by probing compares for both operations.

// File: rtl/pw_guard_pkg.sv
package pw_guard_pkg;
  localparam logic OP_RD = 1'b0;
  localparam logic OP_WR = 1'b1;

  // pick the secret that guards the requested operation
  function automatic logic [63:0] pick_secret(input logic op,
                                              input logic [63:0] rd,
                                              input logic [63:0] wr);
    return (op == OP_WR) ? wr : rd;
  endfunction

  // tally after a failed attempt; wraps to zero when the limit is passed
  function automatic int unsigned tally_after_fail(input int unsigned cur,
                                                   input int unsigned lim);
    return (cur >= lim) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/pw_secret_regs.sv
module pw_secret_regs #(
  parameter int PW_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            ld_i,
  input  logic            ld_sel_i,
  input  logic [PW_W-1:0] ld_val_i,
  output logic [PW_W-1:0] rd_sec_o,
  output logic [PW_W-1:0] wr_sec_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_sec_o <= '0;
      wr_sec_o <= '0;
    end else if (clr_i) begin
      rd_sec_o <= '0;
      wr_sec_o <= '0;
    end else if (ld_i) begin
      if (ld_sel_i) wr_sec_o <= ld_val_i;
      else          rd_sec_o <= ld_val_i;
    end
  end
endmodule

// File: rtl/pw_matcher.sv
module pw_matcher #(
  parameter int PW_W = 64
) (
  input  logic            op_i,
  input  logic [PW_W-1:0] cand_i,
  input  logic [PW_W-1:0] rd_sec_i,
  input  logic [PW_W-1:0] wr_sec_i,
  output logic            hit_o
);
  import pw_guard_pkg::*;
  logic [63:0] sel64;
  logic [63:0] cand64;
  always_comb begin
    sel64  = pick_secret(op_i, 64'(rd_sec_i), 64'(wr_sec_i));
    cand64 = 64'(cand_i);
    hit_o  = (sel64 == cand64);
  end
endmodule

// File: rtl/pw_retry_ctr.sv
module pw_retry_ctr #(
  parameter int MAX_TRIES = 8,
  localparam int CNT_W = $clog2(MAX_TRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pass_i,
  input  logic             fail_i,
  output logic             lock_ev_o,
  output logic [CNT_W-1:0] tries_o
);
  import pw_guard_pkg::*;
  logic [CNT_W-1:0] nxt_fail;
  always_comb begin
    nxt_fail  = CNT_W'(tally_after_fail(32'(tries_o), MAX_TRIES));
    lock_ev_o = fail_i && (tries_o == CNT_W'(MAX_TRIES));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tries_o <= '0;
    else if (pass_i) tries_o <= '0;
    else if (fail_i) tries_o <= nxt_fail;
  end
endmodule

// File: rtl/pw_guard.sv
module pw_guard #(
  parameter int PW_W = 64,
  parameter int MAX_TRIES = 8,
  localparam int CNT_W = $clog2(MAX_TRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_i,
  input  logic             op_i,
  input  logic [PW_W-1:0]  cand_i,
  input  logic             end_i,
  input  logic             chg_i,
  input  logic             chg_sel_i,
  input  logic [PW_W-1:0]  chg_val_i,
  output logic             grant_o,
  output logic             wipe_o,
  output logic [CNT_W-1:0] tries_o
);
  logic [PW_W-1:0] rd_sec, wr_sec;
  logic hit_w, pass_w, fail_w, lock_w, ld_w;
  logic gr_wr_q;

  assign pass_w = cmp_i && hit_w;
  assign fail_w = cmp_i && !hit_w;
  assign ld_w   = chg_i && !cmp_i && grant_o && gr_wr_q;

  pw_matcher #(.PW_W(PW_W)) u_match (
    .op_i(op_i), .cand_i(cand_i), .rd_sec_i(rd_sec), .wr_sec_i(wr_sec),
    .hit_o(hit_w)
  );

  pw_retry_ctr #(.MAX_TRIES(MAX_TRIES)) u_ctr (
    .clk(clk), .rst_n(rst_n), .pass_i(pass_w), .fail_i(fail_w),
    .lock_ev_o(lock_w), .tries_o(tries_o)
  );

  pw_secret_regs #(.PW_W(PW_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .clr_i(lock_w), .ld_i(ld_w),
    .ld_sel_i(chg_sel_i), .ld_val_i(chg_val_i),
    .rd_sec_o(rd_sec), .wr_sec_o(wr_sec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_o <= 1'b0;
      gr_wr_q <= 1'b0;
      wipe_o  <= 1'b0;
    end else begin
      wipe_o <= lock_w;
      if (cmp_i) begin
        grant_o <= hit_w;
        gr_wr_q <= op_i;
      end else if (end_i) begin
        grant_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pw_guard_chk.sv
module pw_guard_chk #(
  parameter int MAX_TRIES = 8,
  localparam int CNT_W = $clog2(MAX_TRIES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmp_i,
  input logic             end_i,
  input logic             hit_w,
  input logic             grant_o,
  input logic             wipe_o,
  input logic [CNT_W-1:0] tries_o
);
  // R3
  pass_grants_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_i && hit_w |=> grant_o && tries_o == '0);
  // R4
  fail_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_i && !hit_w |=> !grant_o);
  // R6
  wipe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_o |=> !wipe_o);
  // R6
  wipe_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_o |-> tries_o == '0 && !grant_o);
  // R7
  end_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_i && !cmp_i |=> !grant_o);
  // R7
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_i && !end_i |=> $stable(grant_o));
  // R9
  tries_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_i |=> $stable(tries_o));
  // R9
  tries_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tries_o <= CNT_W'(MAX_TRIES));
endmodule

bind pw_guard pw_guard_chk #(.MAX_TRIES(MAX_TRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_i(cmp_i), .end_i(end_i), .hit_w(hit_w),
  .grant_o(grant_o), .wipe_o(wipe_o), .tries_o(tries_o)
);

// File: tb/tb_pw_guard.sv
module tb_pw_guard;
  localparam int PW_W = 64;
  localparam int MAXT = 8;
  localparam int CW = $clog2(MAXT + 1);

  logic clk = 0, rst_n = 0;
  logic cmp_i = 0, op_i = 0, end_i = 0, chg_i = 0, chg_sel_i = 0;
  logic [PW_W-1:0] cand_i = '0, chg_val_i = '0;
  logic grant_o, wipe_o;
  logic [CW-1:0] tries_o;

  int n_chk = 0, n_bad = 0;
  logic [PW_W-1:0] m_rd = '0, m_wr = '0;
  int m_cnt = 0;
  logic m_gr = 0, m_gw = 0, m_wipe = 0;

  localparam logic [PW_W-1:0] SA = 64'hA5C3_0F1E_7788_9911;
  localparam logic [PW_W-1:0] SB = 64'h0123_4567_89AB_CDEF;

  always #2.5 clk = ~clk;

  pw_guard #(.PW_W(PW_W), .MAX_TRIES(MAXT)) dut (
    .clk(clk), .rst_n(rst_n), .cmp_i(cmp_i), .op_i(op_i), .cand_i(cand_i),
    .end_i(end_i), .chg_i(chg_i), .chg_sel_i(chg_sel_i), .chg_val_i(chg_val_i),
    .grant_o(grant_o), .wipe_o(wipe_o), .tries_o(tries_o)
  );

  task automatic check(string req);
    n_chk++;
    if (grant_o !== m_gr || wipe_o !== m_wipe || int'(tries_o) != m_cnt) begin
      n_bad++;
      $display("FAIL %s: got grant=%0b wipe=%0b tries=%0d exp grant=%0b wipe=%0b tries=%0d",
               req, grant_o, wipe_o, tries_o, m_gr, m_wipe, m_cnt);
    end
  endtask

  task automatic cyc(input logic stb, input logic op, input logic [PW_W-1:0] cand,
                     input logic en, input logic chg, input logic sel,
                     input logic [PW_W-1:0] val, input string req);
    logic hit;
    @(negedge clk);
    cmp_i = stb; op_i = op; cand_i = cand; end_i = en;
    chg_i = chg; chg_sel_i = sel; chg_val_i = val;
    @(posedge clk);
    #1;
    m_wipe = 0;
    if (stb) begin
      hit = op ? (cand == m_wr) : (cand == m_rd);
      if (hit) begin m_gr = 1; m_gw = op; m_cnt = 0; end
      else if (m_cnt == MAXT) begin
        m_wipe = 1; m_cnt = 0; m_rd = '0; m_wr = '0; m_gr = 0; m_gw = op;
      end else begin m_cnt++; m_gr = 0; m_gw = op; end
    end else begin
      if (chg && m_gr && m_gw) begin
        if (sel) m_wr = val; else m_rd = val;
      end
      if (en) m_gr = 0;
    end
    check(req);
    @(negedge clk);
    cmp_i = 0; end_i = 0; chg_i = 0;
  endtask

  task automatic cmp(input logic op, input logic [PW_W-1:0] c, input string req);
    cyc(1, op, c, 0, 0, 0, '0, req);
  endtask
  task automatic idle(input string req);
    cyc(0, 0, '0, 0, 0, 0, '0, req);
  endtask

  initial begin
    #40000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, got hung exp done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1; check("R1");
    #12; rst_n = 1;
    @(negedge clk); check("R1");
    cmp(0, '0, "R1 read zero");
    cmp(1, '0, "R1 write zero");
    // R8: change both secrets under write grant
    cyc(0, 0, '0, 0, 1, 1, SA, "R8 load wr");
    cyc(0, 0, '0, 0, 1, 0, SB, "R8 load rd");
    idle("R7 hold"); idle("R7 hold");
    cyc(0, 0, '0, 1, 0, 0, '0, "R7 end");
    cmp(1, SA, "R2 wr secret");
    cmp(0, SB, "R2 rd secret");
    // R8: change under read grant ignored
    cyc(0, 0, '0, 0, 1, 1, 64'h1, "R8 ignored rd grant");
    cmp(1, SA, "R8 wr unchanged");
    // R8: change with strobe same cycle ignored
    cyc(1, 1, SA, 0, 1, 0, 64'h2, "R8 ignored strobe");
    cmp(0, SB, "R8 rd unchanged");
    // R2: cross secrets fail
    cmp(0, SA, "R2 rd with wr secret");
    cmp(1, SB, "R2 wr with rd secret");
    cmp(1, SA, "R3 clear");
    // R7: strobe beats end
    cyc(1, 0, SB, 1, 0, 0, '0, "R7 strobe wins");
    cyc(1, 0, SA, 1, 0, 0, '0, "R7 strobe fail wins");
    cmp(0, SB, "R3");
    // R4/R5 sweep of k mixed failures then pass
    for (int k = 0; k <= MAXT; k++) begin
      for (int j = 0; j < k; j++)
        cmp(logic'((j + k) % 2), 64'hDEAD_0000 + 64'(j), "R5 mixed fail");
      cmp(1, SA, "R3 pass resets");
    end
    // R6: overflow
    for (int j = 0; j < MAXT; j++) cmp(logic'(j % 2), ~SA, "R4 fail");
    cmp(0, 64'h3, "R6 wipe");
    idle("R6 pulse ends");
    cmp(0, '0, "R6 rd zero");
    cmp(1, '0, "R6 wr zero");
    // R9 idle keeps count
    cmp(0, 64'h5, "R4 one fail");
    idle("R9 stable"); cyc(0, 0, '0, 1, 0, 0, '0, "R9 stable end");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule